// File: doc/BRIEF.md
# Scanline Sprite Pixel Mixer

This block produces the final colour-lookup address for each pixel of a scanline by combining the sprites chosen for that line with the background pixel. It holds eight sprite units. At the start of a line, one strobe loads every unit with four things: a horizontal start position, two 8-bit pattern planes, a 2-bit palette selector, and a behind-background flag.

After loading, every pixel-advance strobe moves each unit one pixel along the line. A unit first counts its start position down to zero. It then emits its eight pattern pixels, most significant bit first, and after that stays transparent until the next load. A fixed-order selector takes the lowest-numbered unit that shows an opaque pixel at the current position. The selector then merges that pixel with the incoming 4-bit background pixel into a 5-bit palette address.

The address follows the current unit state and the background input without a register in between. The block that owns the palette memory can therefore register it.

Top module: `spr_line_mixer`

## Requirements
- R1: After reset no unit is active. `palAddr` is then `{1'b0, bgPixel}` when `bgPixel[1:0]` is nonzero, and 0 otherwise.
- R2: A `lineLoad` pulse reloads all eight units in the same clock edge. `lineLoad` takes precedence over `pixelEn` in that cycle, and the line position restarts at 0 after the load.
- R3: A unit loaded with start position X shows its sprite pixel i (0..7) after exactly X+i advance edges. X=0 shows pixel 0 directly after the load.
- R4: Each unit emits exactly 8 pixels per load. It is transparent from then on until the next load.
- R5: Unit k takes its fields from `loadX[8k+:8]`, `loadPlaneLo[8k+:8]`, `loadPlaneHi[8k+:8]`, `loadPal[2k+:2]` and `loadBehind[k]`. Sprite pixel i is `{planeHi[7-i], planeLo[7-i]}`.
- R6: A sprite pixel value of 00 is transparent and never wins. The next unit with an opaque pixel shows through it.
- R7: When several units show opaque pixels at one position, the one with the lowest index wins.
- R8: If the winning unit has its behind flag set and the background pattern (`bgPixel[1:0]`) is nonzero, the background is output. If the behind flag is set and the background pattern is zero, the sprite is output.
- R9: A sprite pixel gives `{1'b1, pal, pix}`. An opaque background gives `{1'b0, bgPixel}`. With neither a sprite nor an opaque background the address is 0, whatever `bgPixel[3:2]` holds.
- R10: With `pixelEn` and `lineLoad` both low, unit state holds. `palAddr` does not change while `bgPixel` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineLoad | input | 1 | Line-start strobe that loads all units |
| pixelEn | input | 1 | Advance all units by one pixel |
| loadX | input | 64 | Start positions, 8 bits per unit |
| loadPlaneLo | input | 64 | Low pattern planes, 8 bits per unit |
| loadPlaneHi | input | 64 | High pattern planes, 8 bits per unit |
| loadPal | input | 16 | Palette selectors, 2 bits per unit |
| loadBehind | input | 8 | Behind-background flags, 1 bit per unit |
| bgPixel | input | 4 | Background pixel {palette, pattern} |
| palAddr | output | 5 | Merged palette address |

## Verification
The properties assume that `bgPixel` is driven only between clock edges and held steady across idle cycles. This lets output stability during a hold be tied to the unit state alone. The load property assumes that every start position in the loaded set is nonzero whenever it is applied. The stimulus drives all inputs on the falling edge. It changes the background only at the sampling points of advance cycles, and it recomputes every expected address from the loaded fields and the position count.

// File: rtl/spr_line_pkg.sv
package spr_line_pkg;
  localparam int NUM_UNITS_DEF = 8;
  localparam int POS_W_DEF     = 8;
  localparam int PAT_W_DEF     = 8;
  localparam int PAL_W_DEF     = 2;
  localparam int PIX_W         = 2;

  // Strobes from control to the unit array
  typedef struct packed {
    logic load;
    logic advance;
  } sprStrobe_t;
endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_line_pkg::*;
(
  input  logic       lineLoad,
  input  logic       pixelEn,
  output sprStrobe_t strobe
);
  // A line load overrides a pixel advance in the same cycle
  always_comb begin
    strobe.load    = lineLoad;
    strobe.advance = pixelEn & ~lineLoad;
  end
endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_line_pkg::*;
#(
  parameter int POS_W = POS_W_DEF,
  parameter int PAT_W = PAT_W_DEF,
  parameter int PAL_W = PAL_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  sprStrobe_t       strobe,
  input  logic [POS_W-1:0] loadPos,
  input  logic [PAT_W-1:0] loadLo,
  input  logic [PAT_W-1:0] loadHi,
  input  logic [PAL_W-1:0] loadPal,
  input  logic             loadBehind,
  output logic [PIX_W-1:0] pixel,
  output logic [PAL_W-1:0] pal,
  output logic             behind
);
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [POS_W-1:0] posCnt;
  logic [PAT_W-1:0] shiftLo;
  logic [PAT_W-1:0] shiftHi;
  logic [CNT_W-1:0] pixLeft;
  logic [PAL_W-1:0] palReg;
  logic             behindReg;
  logic             active;

  assign active = (posCnt == '0) && (pixLeft != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt    <= '0;
      shiftLo   <= '0;
      shiftHi   <= '0;
      pixLeft   <= '0;
      palReg    <= '0;
      behindReg <= 1'b0;
    end else if (strobe.load) begin
      posCnt    <= loadPos;
      shiftLo   <= loadLo;
      shiftHi   <= loadHi;
      pixLeft   <= CNT_W'(PAT_W);
      palReg    <= loadPal;
      behindReg <= loadBehind;
    end else if (strobe.advance) begin
      if (posCnt != '0) begin
        posCnt <= posCnt - 1'b1;
      end else if (pixLeft != '0) begin
        shiftLo <= {shiftLo[PAT_W-2:0], 1'b0};
        shiftHi <= {shiftHi[PAT_W-2:0], 1'b0};
        pixLeft <= pixLeft - 1'b1;
      end
    end
  end

  assign pixel  = active ? {shiftHi[PAT_W-1], shiftLo[PAT_W-1]} : '0;
  assign pal    = palReg;
  assign behind = behindReg;
endmodule

// File: rtl/spr_pick.sv
module spr_pick
  import spr_line_pkg::*;
#(
  parameter int NUM_UNITS = NUM_UNITS_DEF,
  parameter int PAL_W     = PAL_W_DEF
) (
  input  logic [NUM_UNITS*PIX_W-1:0] unitPix,
  input  logic [NUM_UNITS*PAL_W-1:0] unitPal,
  input  logic [NUM_UNITS-1:0]       unitBehind,
  input  logic [PAL_W+PIX_W-1:0]     bgPixel,
  output logic [PAL_W+PIX_W:0]       palAddr
);
  logic             found;
  logic [PIX_W-1:0] winPix;
  logic [PAL_W-1:0] winPal;
  logic             winBehind;
  logic             bgOpaque;

  // Scan from the highest index down so the lowest opaque unit is kept
  always_comb begin
    found     = 1'b0;
    winPix    = '0;
    winPal    = '0;
    winBehind = 1'b0;
    for (int k = NUM_UNITS - 1; k >= 0; k--) begin
      if (unitPix[k*PIX_W +: PIX_W] != '0) begin
        found     = 1'b1;
        winPix    = unitPix[k*PIX_W +: PIX_W];
        winPal    = unitPal[k*PAL_W +: PAL_W];
        winBehind = unitBehind[k];
      end
    end
  end

  assign bgOpaque = bgPixel[PIX_W-1:0] != '0;

  always_comb begin
    if (found && !(winBehind && bgOpaque)) begin
      palAddr = {1'b1, winPal, winPix};
    end else if (bgOpaque) begin
      palAddr = {1'b0, bgPixel};
    end else begin
      palAddr = '0;
    end
  end
endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import spr_line_pkg::*;
#(
  parameter int NUM_UNITS = NUM_UNITS_DEF,
  parameter int POS_W     = POS_W_DEF,
  parameter int PAT_W     = PAT_W_DEF,
  parameter int PAL_W     = PAL_W_DEF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sprStrobe_t                 strobe,
  input  logic [NUM_UNITS*POS_W-1:0] loadX,
  input  logic [NUM_UNITS*PAT_W-1:0] loadPlaneLo,
  input  logic [NUM_UNITS*PAT_W-1:0] loadPlaneHi,
  input  logic [NUM_UNITS*PAL_W-1:0] loadPal,
  input  logic [NUM_UNITS-1:0]       loadBehind,
  input  logic [PAL_W+PIX_W-1:0]     bgPixel,
  output logic [PAL_W+PIX_W:0]       palAddr
);
  logic [NUM_UNITS*PIX_W-1:0] unitPix;
  logic [NUM_UNITS*PAL_W-1:0] unitPal;
  logic [NUM_UNITS-1:0]       unitBehind;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    spr_unit #(
      .POS_W(POS_W),
      .PAT_W(PAT_W),
      .PAL_W(PAL_W)
    ) unit_i (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobe),
      .loadPos   (loadX[k*POS_W +: POS_W]),
      .loadLo    (loadPlaneLo[k*PAT_W +: PAT_W]),
      .loadHi    (loadPlaneHi[k*PAT_W +: PAT_W]),
      .loadPal   (loadPal[k*PAL_W +: PAL_W]),
      .loadBehind(loadBehind[k]),
      .pixel     (unitPix[k*PIX_W +: PIX_W]),
      .pal       (unitPal[k*PAL_W +: PAL_W]),
      .behind    (unitBehind[k])
    );
  end

  spr_pick #(
    .NUM_UNITS(NUM_UNITS),
    .PAL_W    (PAL_W)
  ) pick_i (
    .unitPix   (unitPix),
    .unitPal   (unitPal),
    .unitBehind(unitBehind),
    .bgPixel   (bgPixel),
    .palAddr   (palAddr)
  );
endmodule

// File: rtl/spr_line_mixer.sv
module spr_line_mixer
  import spr_line_pkg::*;
#(
  parameter int NUM_UNITS = NUM_UNITS_DEF,
  parameter int POS_W     = POS_W_DEF,
  parameter int PAT_W     = PAT_W_DEF,
  parameter int PAL_W     = PAL_W_DEF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lineLoad,
  input  logic                       pixelEn,
  input  logic [NUM_UNITS*POS_W-1:0] loadX,
  input  logic [NUM_UNITS*PAT_W-1:0] loadPlaneLo,
  input  logic [NUM_UNITS*PAT_W-1:0] loadPlaneHi,
  input  logic [NUM_UNITS*PAL_W-1:0] loadPal,
  input  logic [NUM_UNITS-1:0]       loadBehind,
  input  logic [PAL_W+PIX_W-1:0]     bgPixel,
  output logic [PAL_W+PIX_W:0]       palAddr
);
  sprStrobe_t strobe;

  spr_ctrl ctrl_i (
    .lineLoad(lineLoad),
    .pixelEn (pixelEn),
    .strobe  (strobe)
  );

  spr_datapath #(
    .NUM_UNITS(NUM_UNITS),
    .POS_W    (POS_W),
    .PAT_W    (PAT_W),
    .PAL_W    (PAL_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .loadX      (loadX),
    .loadPlaneLo(loadPlaneLo),
    .loadPlaneHi(loadPlaneHi),
    .loadPal    (loadPal),
    .loadBehind (loadBehind),
    .bgPixel    (bgPixel),
    .palAddr    (palAddr)
  );
endmodule

// File: rtl/spr_line_mixer_chk.sv
module spr_line_mixer_chk
  import spr_line_pkg::*;
#(
  parameter int NUM_UNITS = NUM_UNITS_DEF,
  parameter int POS_W     = POS_W_DEF,
  parameter int PAL_W     = PAL_W_DEF
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       lineLoad,
  input logic                       pixelEn,
  input logic [NUM_UNITS*POS_W-1:0] loadX,
  input logic [PAL_W+PIX_W-1:0]     bgPixel,
  input logic [PAL_W+PIX_W:0]       palAddr
);
  logic allXNonzero;
  always_comb begin
    allXNonzero = 1'b1;
    for (int k = 0; k < NUM_UNITS; k++) begin
      if (loadX[k*POS_W +: POS_W] == '0) allXNonzero = 1'b0;
    end
  end

  // R9
  sprite_pix_opaque_chk: assert property (@(posedge clk) disable iff (!rstN)
    palAddr[PAL_W+PIX_W] |-> (palAddr[PIX_W-1:0] != '0));

  // R9
  bg_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !palAddr[PAL_W+PIX_W] |->
      ((palAddr == '0 && bgPixel[PIX_W-1:0] == '0) ||
       (palAddr[PAL_W+PIX_W-1:0] == bgPixel && bgPixel[PIX_W-1:0] != '0)));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (palAddr[PIX_W-1:0] == '0) |-> (palAddr == '0));

  // R2
  load_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineLoad && allXNonzero) |=> !palAddr[PAL_W+PIX_W]);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pixelEn && !lineLoad) ##1 $stable(bgPixel) |-> $stable(palAddr));
endmodule

bind spr_line_mixer spr_line_mixer_chk #(
  .NUM_UNITS(NUM_UNITS),
  .POS_W    (POS_W),
  .PAL_W    (PAL_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .lineLoad(lineLoad),
  .pixelEn (pixelEn),
  .loadX   (loadX),
  .bgPixel (bgPixel),
  .palAddr (palAddr)
);

// File: tb/spr_line_mixer_tb_top.sv
`timescale 1ns/1ps
module spr_line_mixer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineLoad = 1'b0;
  logic        pixelEn = 1'b0;
  logic [63:0] loadX = '0;
  logic [63:0] loadPlaneLo = '0;
  logic [63:0] loadPlaneHi = '0;
  logic [15:0] loadPal = '0;
  logic [7:0]  loadBehind = '0;
  logic [3:0]  bgPixel = '0;
  logic [4:0]  palAddr;

  int checks = 0;
  int fails = 0;
  int pos = 0;
  bit done = 0;

  logic [7:0] xs [8];
  logic [7:0] lo [8];
  logic [7:0] hi [8];
  logic [1:0] pal [8];
  logic       beh [8];

  always #2.5 clk = ~clk;

  spr_line_mixer dut_i (
    .clk(clk), .rstN(rstN), .lineLoad(lineLoad), .pixelEn(pixelEn),
    .loadX(loadX), .loadPlaneLo(loadPlaneLo), .loadPlaneHi(loadPlaneHi),
    .loadPal(loadPal), .loadBehind(loadBehind), .bgPixel(bgPixel),
    .palAddr(palAddr)
  );

  function automatic logic [4:0] model(int p, logic [3:0] bg);
    bit found = 0;
    logic [1:0] wp = 0, wpal = 0, px;
    logic wb = 0;
    for (int k = 0; k < 8; k++) begin
      int i = p - int'(xs[k]);
      if (i >= 0 && i < 8) begin
        px = {hi[k][7-i], lo[k][7-i]};
        if (px != 0 && !found) begin
          found = 1; wp = px; wpal = pal[k]; wb = beh[k];
        end
      end
    end
    if (found && !(wb && bg[1:0] != 0)) return {1'b1, wpal, wp};
    if (bg[1:0] != 0) return {1'b0, bg};
    return 5'd0;
  endfunction

  function automatic logic [3:0] bgFor(int mode, int p);
    if (mode == 0) return 4'b1000;
    return 4'((p * 5 + 1) & 15);
  endfunction

  task automatic chk(logic [4:0] act, logic [4:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, pos, act, exp);
    end
  endtask

  task automatic clearCfg();
    for (int k = 0; k < 8; k++) begin
      xs[k] = 8'd0; lo[k] = 8'd0; hi[k] = 8'd0; pal[k] = 2'd0; beh[k] = 1'b0;
    end
  endtask

  task automatic loadLine(bit withEn);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      loadX[k*8 +: 8] = xs[k];
      loadPlaneLo[k*8 +: 8] = lo[k];
      loadPlaneHi[k*8 +: 8] = hi[k];
      loadPal[k*2 +: 2] = pal[k];
      loadBehind[k] = beh[k];
    end
    lineLoad = 1'b1;
    pixelEn = withEn;
    @(posedge clk);
    #1;
    lineLoad = 1'b0;
    pixelEn = 1'b0;
    pos = 0;
  endtask

  task automatic sampleAt(int mode, string tag);
    bgPixel = bgFor(mode, pos);
    #0.5;
    chk(palAddr, model(pos, bgPixel), tag);
  endtask

  task automatic advance();
    @(negedge clk);
    pixelEn = 1'b1;
    @(posedge clk);
    #1;
    pixelEn = 1'b0;
    pos++;
  endtask

  task automatic runLine(int n, int mode, string tag);
    sampleAt(mode, tag);
    for (int s = 0; s < n; s++) begin
      advance();
      sampleAt(mode, tag);
    end
  endtask

  task automatic testReset();
    bgPixel = 4'b0110; #0.5;
    chk(palAddr, 5'b00110, "R1 opaque bg");
    bgPixel = 4'b1100; #0.5;
    chk(palAddr, 5'b00000, "R1 R9 transparent bg");
  endtask

  task automatic testSingle();
    clearCfg();
    xs[3] = 8'd3; lo[3] = 8'b1010_0110; hi[3] = 8'b1100_1010; pal[3] = 2'd2;
    loadLine(0);
    runLine(14, 0, "R3 R4 R5 single");
  endtask

  task automatic testPriority();
    clearCfg();
    xs[1] = 8'd2; lo[1] = 8'hF0; pal[1] = 2'd1;
    xs[4] = 8'd0; lo[4] = 8'hFF; hi[4] = 8'hFF; pal[4] = 2'd3;
    xs[6] = 8'd4; hi[6] = 8'hAA; pal[6] = 2'd2;
    loadLine(0);
    runLine(16, 0, "R6 R7 R9 priority");
  endtask

  task automatic testBehind();
    clearCfg();
    xs[0] = 8'd1; lo[0] = 8'hFF; hi[0] = 8'h55; pal[0] = 2'd1; beh[0] = 1'b1;
    xs[5] = 8'd5; lo[5] = 8'h3C; hi[5] = 8'hC3; pal[5] = 2'd3;
    loadLine(0);
    runLine(16, 1, "R8 R9 behind");
  endtask

  task automatic testHold();
    clearCfg();
    xs[2] = 8'd2; lo[2] = 8'b1101_0010; hi[2] = 8'b0110_1001; pal[2] = 2'd1;
    loadLine(0);
    for (int s = 0; s < 4; s++) advance();
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      @(posedge clk);
      #1;
      sampleAt(0, "R10 hold");
    end
    runLine(8, 0, "R10 resume");
  endtask

  task automatic testReload();
    clearCfg();
    xs[0] = 8'd0; lo[0] = 8'hFF; pal[0] = 2'd1;
    loadLine(0);
    for (int s = 0; s < 6; s++) advance();
    clearCfg();
    xs[7] = 8'd1; lo[7] = 8'h81; hi[7] = 8'hFF; pal[7] = 2'd2;
    xs[3] = 8'd3; lo[3] = 8'hFF; pal[3] = 2'd3;
    loadLine(1);
    runLine(12, 1, "R2 reload");
  endtask

  task automatic testEdges();
    clearCfg();
    xs[2] = 8'd0; lo[2] = 8'h5A; hi[2] = 8'h0F; pal[2] = 2'd1;
    xs[6] = 8'd255; lo[6] = 8'hFF; hi[6] = 8'hFF; pal[6] = 2'd3;
    xs[7] = 8'd12; lo[7] = 8'hFF; hi[7] = 8'h00; pal[7] = 2'd2;
    loadLine(0);
    runLine(22, 0, "R3 R4 edges");
  endtask

  initial begin
    clearCfg();
    #12;
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testSingle();
    testPriority();
    testBehind();
    testHold();
    testReload();
    testEdges();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule